// File: doc/BRIEF.md
# Sync Pulse Glitch Filter

This block cleans up a horizontal sync signal that arrives asynchronously to the oscillator clock. The raw input first passes through a multi-stage synchroniser. A persistence qualifier then accepts a new level only after the synchronised input has shown that level on two clock samples in a row. A lone one-sample excursion in either direction, or an excursion too short to be sampled at all, therefore never reaches the output. The output goes high or low only once the input has held its new level long enough.

A bypass control sends the synchronised input straight to the output and skips the qualifier. The control is sampled on the clock, so a change to it takes effect at the next edge. While in bypass, the qualifier's state is loaded with the synchronised level. Leaving bypass therefore starts from an agreed level and cannot create a pulse. Polarity detection, frequency measurement and clamp generation sit elsewhere.

Top module: `sync_glitch_filter`

## Requirements
- R1: While reset is low and on the first edge after it, `sync_out` is 0. The synchroniser and qualifier state are also cleared to 0.
- R2: With `filter_off` = 0, an input excursion that is seen by at most one clock sample, or by none, does not change `sync_out`.
- R3: With `filter_off` = 0, a high pulse seen by N >= 2 consecutive samples appears on `sync_out` as a high pulse exactly N clocks wide.
- R4: The qualifier is symmetric. With `filter_off` = 0, a one-sample low dip inside a high level is suppressed, and a low level held for two samples or more passes.
- R5: With `filter_off` = 0, a level change that holds is first visible on `sync_out` after the 4th rising edge, counting the first edge that samples the new level as edge 1.
- R6: With `filter_off` = 1, `sync_out` copies the input sampled 3 edges earlier, and single-sample pulses pass.
- R7: A change of `filter_off` acts at the next clock edge. Going from bypass back to filtering keeps the current output level and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_in | input | 1 | Raw asynchronous sync input |
| filter_off | input | 1 | 1 = bypass the qualifier, 0 = filter |
| sync_out | output | 1 | Filtered sync output |

## Verification
Directed pulses of one, two and several samples, in both polarities, separate suppression from pass-through and show whether the output width matches. A glitch placed entirely between two clock edges shows that unsampled noise is invisible. A held step measures the latency, in edges, through synchroniser and qualifier. Random bursts of mixed widths, with the bypass bit switching at random points, are compared cycle by cycle against a bench model. These bursts expose wrong widths, wrong latency and any spurious pulse at a mode change.

// File: rtl/sgf_pkg.sv
// Package: shared defaults for the sync glitch filter.
// Assumes: consumers take the defaults and may override them per instance.
package sgf_pkg;
    parameter int unsigned SGF_SYNC_STAGES = 2; // synchroniser flops
    parameter int unsigned SGF_HOLD        = 2; // samples a new level must persist

    // Width of a counter that reaches (n - 1), never less than one bit.
    function automatic int unsigned sgf_cnt_w(input int unsigned n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sgf_sync.sv
// Module: sgf_sync
// Multi-flop synchroniser that brings the raw input into the clock domain.
// Assumes: STAGES >= 2; reset value of every stage is 0.
module sgf_sync #(
    parameter int unsigned STAGES = sgf_pkg::SGF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Purpose: capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Purpose: let metastability settle through one more flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sgf_qualifier.sv
// Module: sgf_qualifier
// Persistence qualifier: the output moves to a new level only after the
// input has differed from it on HOLD consecutive samples. In bypass, the
// output is loaded with the input every cycle and the run counter is cleared.
// Assumes: d is already synchronous to clk; HOLD >= 1.
module sgf_qualifier #(
    parameter int unsigned HOLD = sgf_pkg::SGF_HOLD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic d,
    output logic q
);
    localparam int unsigned CW = sgf_pkg::sgf_cnt_w(HOLD);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] run;

    // Purpose: count differing samples and commit the new level at HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            run <= '0;
        end else if (bypass) begin
            q   <= d;
            run <= '0;
        end else if (d == q) begin
            run <= '0;
        end else if (run == LAST) begin
            q   <= d;
            run <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/sync_glitch_filter.sv
// Module: sync_glitch_filter
// Top level: synchroniser followed by the persistence qualifier, with a
// clock-sampled bypass bit.
// Assumes: clk is the oscillator clock; rst_n is synchronous, active low.
module sync_glitch_filter #(
    parameter int unsigned SYNC_STAGES = sgf_pkg::SGF_SYNC_STAGES,
    parameter int unsigned HOLD        = sgf_pkg::SGF_HOLD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic filter_off,
    output logic sync_out
);
    logic sync_q;

    sgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sync_in),
        .q_sync  (sync_q)
    );

    sgf_qualifier #(.HOLD(HOLD)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .bypass (filter_off),
        .d      (sync_q),
        .q      (sync_out)
    );
endmodule

// File: rtl/sgf_checker.sv
// Module: sgf_checker
// Temporal checks on the filter, attached to the top through bind.
// Assumes: the default HOLD of two samples and the default synchroniser depth.
module sgf_checker (
    input logic clk,
    input logic rst_n,
    input logic filter_off,
    input logic sync_q,
    input logic sync_out
);
    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(sync_out)); // R1

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!filter_off && sync_out != $past(sync_out))
        |=> (filter_off || sync_out == $past(sync_out))); // R2

    AST_TWO_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(filter_off) && !$past(filter_off, 2) && sync_out != $past(sync_out))
        |-> ($past(sync_q) == sync_out && $past(sync_q, 2) == sync_out)); // R4

    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(filter_off) |-> sync_out == $past(sync_q)); // R6
endmodule

bind sync_glitch_filter sgf_checker u_sgf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .filter_off (filter_off),
    .sync_q     (sync_q),
    .sync_out   (sync_out)
);

// File: tb/sim_sync_glitch_filter.sv
module sim_sync_glitch_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic filter_off = 1'b0;
    logic sync_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Model history: input sampled 1, 2 and 3 edges back, bypass 1 edge back.
    logic x1 = 0, x2 = 0, x3 = 0, byp_p = 0, q_exp = 0;

    always #4 clk = ~clk; // 125 MHz

    sync_glitch_filter u0 (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .filter_off(filter_off), .sync_out(sync_out)
    );

    // Expected output after an edge: bypass copies the level sampled two
    // edges earlier; filtering commits it after two differing samples.
    function automatic logic next_q(input logic q, input logic a, input logic b,
                                    input logic byp, input logic byp_prev);
        if (byp) return a;
        if (a != q && b != q && !byp_prev) return a;
        return q;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: sync_out=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising
    // edge, and compare at the next falling edge.
    task automatic step(input logic din, input logic off, input string tag, input bit glitch = 0);
        sync_in = din;
        filter_off = off;
        if (glitch) begin
            #1 sync_in = ~din;
            #1 sync_in = din;
        end
        @(posedge clk);
        q_exp = next_q(q_exp, x2, x3, off, byp_p);
        x3 = x2; x2 = x1; x1 = din; byp_p = off;
        @(negedge clk);
        check(tag, sync_out, q_exp);
    endtask

    task automatic hold(input logic din, input logic off, input int n, input string tag);
        for (int i = 0; i < n; i++) step(din, off, tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: sync_out=%0b expected finish", sync_out);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        sync_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 in reset", sync_out, 1'b0);
        rst_n = 1'b1;
        sync_in = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 after reset", sync_out, 1'b0);
        hold(0, 0, 4, "R1 idle");

        // R5: a held step appears after edge 4 and not before.
        step(1, 0, "R5 e1"); check("R5 e1", sync_out, 1'b0);
        step(1, 0, "R5 e2"); check("R5 e2", sync_out, 1'b0);
        step(1, 0, "R5 e3"); check("R5 e3", sync_out, 1'b0);
        step(1, 0, "R5 e4"); check("R5 e4", sync_out, 1'b1);
        hold(1, 0, 3, "R5 hold");
        // R4: one-sample low dip is suppressed, then a two-sample low passes.
        step(0, 0, "R4 dip");
        hold(1, 0, 6, "R4 after dip");
        hold(0, 0, 2, "R4 low pass");
        hold(0, 0, 6, "R4 low settle");

        // R2: one-sample high pulse and an unsampled glitch are suppressed.
        step(1, 0, "R2 single");
        hold(0, 0, 6, "R2 after single");
        step(0, 0, "R2 subcycle", 1);
        hold(0, 0, 6, "R2 after subcycle");

        // R3: pulses of two and five samples pass with their widths.
        hold(1, 0, 2, "R3 width2");
        hold(0, 0, 6, "R3 gap");
        hold(1, 0, 5, "R3 width5");
        hold(0, 0, 8, "R3 gap");

        // R6: bypass passes single-sample pulses after 3 edges.
        hold(0, 1, 3, "R6 enter");
        step(1, 1, "R6 single");
        step(0, 1, "R6 e2"); check("R6 e2", sync_out, 1'b0);
        step(0, 1, "R6 e3"); check("R6 e3", sync_out, 1'b1);
        hold(0, 1, 4, "R6 tail");

        // R7: leaving bypass at a high level keeps it with no pulse.
        hold(1, 1, 5, "R7 bypass high");
        hold(1, 0, 6, "R7 filter high");
        check("R7 level kept", sync_out, 1'b1);
        step(0, 0, "R7 dip");
        step(1, 1, "R7 toggle");
        hold(1, 0, 6, "R7 settle");

        // Random bursts with occasional bypass changes.
        begin
            logic lvl = 0;
            logic off = 0;
            for (int b = 0; b < 4000; b++) begin
                int w;
                w = 1 + ($urandom % 5);
                lvl = ~lvl;
                if (($urandom % 12) == 0) off = ~off;
                for (int i = 0; i < w; i++)
                    step(lvl, off, off ? "R6 random" : "R3 random", ($urandom % 9) == 0);
            end
        end
        hold(0, 0, 8, "R2 random tail");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule